// File: doc/BRIEF.md
# Grouped Interrupt Aggregator Register Bank

This block gathers up to 31 interrupt request lines into a single group and presents them to software through a small 32-bit register bus. Every request is latched into a sticky pending bit the moment it is seen. Latching does not depend on whether that line is enabled, so software can poll events it has chosen not to be interrupted by. A pending bit stays set until software writes a one to its position.

The per-line enable mask is never written directly. One alias turns bits on and a second alias turns bits off, and each acts only on the positions written as one. Software can therefore change one line's enable without a read-modify-write race. A read-only masked view (pending AND enabled) is also provided. The single group interrupt output is high whenever any bit of that masked view is set.

A parameter marks which of the 31 positions exist. Positions marked absent, and the top bit of every register, are held at zero.

Top module: `irq_group_bank`

## Requirements
- R1: While reset is asserted and right after it is released, the pending and enable bits are all zero, every register reads zero and the group output is low.
- R2: A request line that is high at a clock edge sets its pending bit, whether or not its enable is set. The bit stays set after the request drops. Pending is read at offset 0x0.
- R3: Writing offset 0x0 clears each pending bit whose data bit is one. Data bits that are zero leave pending bits unchanged.
- R4: If a request and a clear of the same pending bit come in the same cycle, the bit remains set.
- R5: Writing offset 0x4 sets each enable bit whose data bit is one. Zero data bits change nothing. Reading 0x4 returns the current enable bits.
- R6: Writing offset 0xC clears each enable bit whose data bit is one. Zero data bits change nothing. Reading 0xC returns the same enable bits as 0x4.
- R7: Offset 0x8 reads pending AND enable bit by bit, and writes to it have no effect.
- R8: The group output is high exactly when the value readable at 0x8 is nonzero, and it follows register state with no further delay.
- R9: Bit 31 of every register and each position whose implemented-mask bit is zero read as zero, cannot be set by requests or writes, and never raise the group output.
- R10: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return zero, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC (31) | Interrupt request lines, sampled each clock edge |
| bus_addr | input | ADDR_W (5) | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| group_irq | output | 1 | OR of all masked pending bits |

## Verification
The bench checks that a request landing in the same cycle as its own clear survives. A design that lets the clear win would drop an event, and the 0x0 read would show zero. It also checks that zero data bits written to the clear register and to both enable aliases leave state alone. A design that stores the data word outright would wipe neighbouring bits, and a later read-back would show it. With bit 15 marked unimplemented and all-ones writes and requests applied, that bit and bit 31 must stay zero. Writes to the masked view and to an unmapped offset must not alter state, which the bench shows through the later reads and the group output.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    // Byte offsets of the four registers; the bench and software rely on these.
    localparam int unsigned OFS_PENDING = 'h0;
    localparam int unsigned OFS_EN_SET  = 'h4;
    localparam int unsigned OFS_MASKED  = 'h8;
    localparam int unsigned OFS_EN_CLR  = 'hC;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_EN_SET  = 3'd2,
        SEL_MASKED  = 3'd3,
        SEL_EN_CLR  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic clr_pending;
        logic set_enable;
        logic clr_enable;
    } wr_strobe_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_grp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_sel_e          sel_o,
    output wr_strobe_t        strobe_o
);

    localparam int CMP_W = (ADDR_W > 8) ? ADDR_W : 8;

    logic [CMP_W-1:0] addr_ext;

    always_comb begin
        addr_ext = '0;
        addr_ext[ADDR_W-1:0] = addr_i;
        if (addr_ext == CMP_W'(OFS_PENDING))
            sel_o = SEL_PENDING;
        else if (addr_ext == CMP_W'(OFS_EN_SET))
            sel_o = SEL_EN_SET;
        else if (addr_ext == CMP_W'(OFS_MASKED))
            sel_o = SEL_MASKED;
        else if (addr_ext == CMP_W'(OFS_EN_CLR))
            sel_o = SEL_EN_CLR;
        else
            sel_o = SEL_NONE;
    end

    // The masked view and unmapped offsets raise no strobe (R7, R10).
    always_comb begin
        strobe_o             = '0;
        strobe_o.clr_pending = wr_i && (sel_o == SEL_PENDING);
        strobe_o.set_enable  = wr_i && (sel_o == SEL_EN_SET);
        strobe_o.clr_enable  = wr_i && (sel_o == SEL_EN_CLR);
    end

    always_comb begin
        assert ($countones({strobe_o.clr_pending, strobe_o.set_enable,
                            strobe_o.clr_enable}) <= 1)
            else $error("p_single_strobe_r10: more than one write strobe");
    end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int               NUM_SRC   = 31,
    parameter logic [NUM_SRC-1:0] IMPL_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] pending_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pending;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_eff;
    logic [NUM_SRC-1:0] req_eff;

    always_comb begin
        clr_eff = clr_en_i ? clr_bits_i : '0;
        req_eff = req_i & IMPL_MASK;
        st_d = st_q;
        // A request in the same cycle overrides the clear (R4).
        st_d.pending = ((st_q.pending & ~clr_eff) | req_eff) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pending;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & $past(req_i & IMPL_MASK)) == $past(req_i & IMPL_MASK)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en_i |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

    p_clear_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((pending_o & $past(clr_bits_i & ~req_i)) == '0));

    p_unimpl_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & ~IMPL_MASK) == '0);

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int               NUM_SRC   = 31,
    parameter logic [NUM_SRC-1:0] IMPL_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] enable_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
    } en_state_t;

    en_state_t st_d, st_q;
    logic [NUM_SRC-1:0] set_bits;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        set_bits = set_en_i ? bits_i : '0;
        clr_bits = clr_en_i ? bits_i : '0;
        st_d = st_q;
        st_d.enable = ((st_q.enable | set_bits) & ~clr_bits) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;

    p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((enable_o & $past(bits_i & IMPL_MASK)) == $past(bits_i & IMPL_MASK)));

    p_clear_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((enable_o & $past(bits_i)) == '0));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(enable_o));

    p_unimpl_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o & ~IMPL_MASK) == '0);

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_grp_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int DATA_W  = 32
) (
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] pending_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic [NUM_SRC-1:0] masked_i,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] field;

    always_comb begin
        unique case (sel_i)
            SEL_PENDING: field = pending_i;
            SEL_EN_SET:  field = enable_i;
            SEL_EN_CLR:  field = enable_i;
            SEL_MASKED:  field = masked_i;
            default:     field = '0;
        endcase
        rdata_o = {{PAD_W{1'b0}}, field};
    end

    always_comb begin
        if (sel_i == SEL_NONE)
            assert (rdata_o == '0) else $error("p_unmapped_zero_r10: nonzero read");
    end

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
    import irq_grp_pkg::*;
#(
    parameter int                 NUM_SRC   = 31,
    parameter int                 DATA_W    = 32,
    parameter int                 ADDR_W    = 5,
    parameter logic [NUM_SRC-1:0] IMPL_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               group_irq
);

    reg_sel_e           sel;
    wr_strobe_t         strobe;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] wbits;
    logic               unused_wdata_hi;

    assign wbits           = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .sel_o    (sel),
        .strobe_o (strobe)
    );

    irq_pending_bank #(.NUM_SRC(NUM_SRC), .IMPL_MASK(IMPL_MASK)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (irq_req),
        .clr_en_i   (strobe.clr_pending),
        .clr_bits_i (wbits),
        .pending_o  (pending)
    );

    irq_enable_bank #(.NUM_SRC(NUM_SRC), .IMPL_MASK(IMPL_MASK)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (strobe.set_enable),
        .clr_en_i (strobe.clr_enable),
        .bits_i   (wbits),
        .enable_o (enable)
    );

    assign masked    = pending & enable;
    assign group_irq = |masked;

    irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rmux (
        .sel_i     (sel),
        .pending_i (pending),
        .enable_i  (enable),
        .masked_i  (masked),
        .rdata_o   (bus_rdata)
    );

    p_reserved_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1] == 1'b0);

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        group_irq |-> (enable != '0) && (pending != '0));

    p_masked_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_MASKED && irq_req == '0) |=> $stable(pending) && $stable(enable));

    p_unmapped_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_NONE && irq_req == '0) |=> $stable(pending) && $stable(enable));

endmodule

// File: tb/irq_group_bank_test.sv
`timescale 1ns/100ps
module irq_group_bank_test;

    localparam int NS = 31;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam logic [NS-1:0] IMPL = 31'h7FFF_7FFF;  // bit 15 absent

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          group_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irq_group_bank #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .IMPL_MASK(IMPL)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .group_irq(group_irq)
    );

    typedef struct packed {
        logic [NS-1:0] req;
        logic          wr;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic [AW-1:0] raddr;
        logic [DW-1:0] exp_rd;
        logic          exp_irq;
        logic [7:0]    rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{31'h3,   1'b0, 5'h00, 32'h0,          5'h00, 32'h0000_0003, 1'b0, 8'd2},  // R2 capture w/o enable
        '{31'h0,   1'b1, 5'h04, 32'h1,          5'h04, 32'h0000_0001, 1'b1, 8'd5},  // R5, R8
        '{31'h0,   1'b1, 5'h0C, 32'h0,          5'h0C, 32'h0000_0001, 1'b1, 8'd6},  // R6 zero no effect
        '{31'h0,   1'b1, 5'h08, 32'hFFFF_FFFF,  5'h08, 32'h0000_0001, 1'b1, 8'd7},  // R7 write ignored
        '{31'h0,   1'b1, 5'h00, 32'h0,          5'h00, 32'h0000_0003, 1'b1, 8'd3},  // R3 zero no effect
        '{31'h0,   1'b1, 5'h00, 32'h1,          5'h00, 32'h0000_0002, 1'b0, 8'd3},  // R3 clear, R8 low
        '{31'h0,   1'b1, 5'h04, 32'hFFFF_FFFF,  5'h04, 32'h7FFF_7FFF, 1'b1, 8'd9},  // R9 enable mask
        '{31'h0,   1'b1, 5'h0C, 32'h2,          5'h04, 32'h7FFF_7FFD, 1'b0, 8'd6},  // R6 clear alias
        '{31'h7FFF_FFFF, 1'b0, 5'h00, 32'h0,    5'h00, 32'h7FFF_7FFF, 1'b1, 8'd9},  // R9 pending mask
        '{31'h0,   1'b1, 5'h10, 32'hFFFF_FFFF,  5'h10, 32'h0000_0000, 1'b1, 8'd10}, // R10 unmapped read
        '{31'h0,   1'b0, 5'h00, 32'h0,          5'h04, 32'h7FFF_7FFD, 1'b1, 8'd10}, // R10 write ignored
        '{31'h0,   1'b1, 5'h00, 32'hFFFF_FFFF,  5'h08, 32'h0000_0000, 1'b0, 8'd3}   // R3 clear all
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [AW-1:0] a);
        bus_addr = a;
        #0.5;
    endtask

    // Drive one cycle at the falling edge, return just after the rising edge with inputs idle.
    task automatic cycle(input logic [NS-1:0] rq, input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        @(negedge clk);
        irq_req = rq; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        irq_req = '0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        #0.5;
        // R1: during reset
        read_at(5'h00); check("R1 pending in reset", bus_rdata, 32'h0);
        check("R1 irq in reset", {31'h0, group_irq}, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        read_at(5'h04); check("R1 enable after reset", bus_rdata, 32'h0);
        read_at(5'h08); check("R1 masked after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].req, VECS[i].wr, VECS[i].waddr, VECS[i].wdata);
            read_at(VECS[i].raddr);
            check($sformatf("R%0d vec %0d rdata", VECS[i].rq, i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("R%0d vec %0d irq", VECS[i].rq, i), {31'h0, group_irq},
                  {31'h0, VECS[i].exp_irq});
        end

        // R4: request and clear on the same bit in the same cycle
        cycle(31'h10, 1'b0, 5'h00, 32'h0);
        cycle(31'h10, 1'b1, 5'h00, 32'h10);
        read_at(5'h00); check("R4 request beats clear", bus_rdata, 32'h0000_0010);
        cycle(31'h0, 1'b1, 5'h00, 32'h10);
        read_at(5'h00); check("R4 plain clear", bus_rdata, 32'h0);

        // R6: both aliases read the same enable bits
        read_at(5'h0C); check("R6 clear alias reads enable", bus_rdata, 32'h7FFF_7FFD);

        // R1: reset in mid-run clears state
        cycle(31'h1, 1'b1, 5'h04, 32'h1);
        check("R8 irq before reset", {31'h0, group_irq}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        #0.5; check("R1 irq under reset", {31'h0, group_irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        read_at(5'h00); check("R1 pending after re-reset", bus_rdata, 32'h0);
        read_at(5'h04); check("R1 enable after re-reset", bus_rdata, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule